// File: doc/BRIEF.md
# Secure System Configuration Register Bank

This block is a bank of system configuration registers on a simple 32-bit register bus. Each bus access carries a secure or non-secure attribute. The bank holds four kinds of state:

- lock bits that software can set once and that only a reset clears;
- erase-completion flags that hardware raises and software clears by writing 1, one of which survives a system reset;
- an FPU exception interrupt mask;
- a control field for an I/O compensation cell. This field picks whether the cell is driven by a code that software wrote or by the value the cell measured itself.

Reads are combinational. A write takes effect on the rising clock edge at which `bus_sel_i` and `bus_wr_i` are both high. Word offsets (in bytes) are:

| Offset | Register |
|---|---|
| 0x00 | security control |
| 0x04 | I/O switch and drive |
| 0x08 | FPU mask |
| 0x0C | non-secure CPU lock |
| 0x10 | secure CPU lock |
| 0x14 | break-routing lock |
| 0x18 | erase status |
| 0x1C | compensation control/status |
| 0x20 | compensation value |
| 0x24 | compensation code |
| 0x2C | command |

Every other offset is unmapped. The lock, routing-enable, drive, command and compensation outputs go straight to neighbouring logic. Two active-low asynchronous resets are provided: a power-on reset and a system reset.

The design has no sequencing, so it holds no state machine. The address decodes to an enumerated register identifier, and a single `unique case` on that identifier selects the read data and the write enables.

Top module: `syscfg_bank`

## Requirements
- R1: Power-on reset (`por_n_i` low) clears every register bit. System reset (`sys_n_i` low) clears every bit except erase-status bit 0.
- R2: Break-routing lock bits [3:0] at 0x14 drive `brk_en_o`. A written 1 sets a bit. A written 0 has no effect. Only a reset clears these bits.
- R3: Non-secure CPU lock bits [1:0] at 0x0C drive `ns_lock_o`, and secure CPU lock bits [2:0] at 0x10 drive `s_lock_o`. Both registers are set-once, cleared only by reset.
- R4: Erase-status bit 0 at 0x18 is set by a high cycle on `erase_all_done_i`. A write with bit 0 = 1 clears it. System reset does not clear it. If a set and a clear arrive in the same cycle, the set wins.
- R5: Erase-status bit 16 at 0x18 is set by a high cycle on `erase_cache_done_i` and is cleared by a write with bit 16 = 1.
- R6: At 0x1C, bit 0 drives `comp_en_o` and bit 1 selects the code source. With bit 1 = 1, `comp_code_o` equals the code register at 0x24 (bits [7:0]: NMOS in [3:0], PMOS in [7:4]). With bit 1 = 0, `comp_code_o` equals `cell_val_i`.
- R7: Bit 8 at 0x1C reads `cell_rdy_i` while `osc_en_i` is high, and reads 0 while `osc_en_i` is low.
- R8: FPU mask bits [5:0] at 0x08 enable, from bit 0 upward: invalid, divide-by-zero, underflow, overflow, input-abnormal and inexact. `fpu_irq_o` is the OR of the enabled `fpu_exc_i` bits, which use the same order.
- R9: Security control bits at 0x00 guard groups of registers. Bit 0 guards 0x18, 0x1C, 0x20 and 0x24. Bit 1 guards 0x14. Bit 3 guards 0x08. While a guard bit is set, non-secure reads of its registers return 0 and non-secure writes to them are ignored.
- R10: The security control register (only bits 0, 1 and 3 are writable) accepts secure writes only. Any bus access may read it.
- R11: The compensation value register at 0x20 is read-only and returns `cell_val_i` in bits [7:0]. Writes to it, or to an unmapped offset, change nothing. Unmapped reads return 0.
- R12: At 0x04, bit 8 drives `sw_boost_o`, bit 9 drives `sw_vsel_o`, and bits [19:16] drive `fmp_en_o`. The command register at 0x2C keeps bits [15:0] and drives `cmd_o`. All other bits of both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| sys_n_i | input | 1 | System reset, active low, asynchronous |
| bus_sel_i | input | 1 | Access valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_secure_i | input | 1 | 1 = secure access |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| erase_all_done_i | input | 1 | Full-erase completion pulse |
| erase_cache_done_i | input | 1 | Cache/crypto-RAM erase completion pulse |
| cell_rdy_i | input | 1 | Compensation cell ready |
| osc_en_i | input | 1 | Internal oscillator enabled |
| cell_val_i | input | 2*CODE_HALF | Measured compensation value |
| fpu_exc_i | input | FPU_N | FPU exception flags |
| brk_en_o | output | BRK_N | Fault-to-timer-break routing enables |
| ns_lock_o | output | NSLK_N | Non-secure CPU register write locks |
| s_lock_o | output | SLK_N | Secure CPU register write locks |
| fmp_en_o | output | FMP_N | Strong-drive enables |
| sw_boost_o | output | 1 | Analog switch booster enable |
| sw_vsel_o | output | 1 | Analog switch supply select |
| comp_en_o | output | 1 | Compensation cell enable |
| comp_code_o | output | 2*CODE_HALF | Code applied to the cell |
| fpu_irq_o | output | 1 | FPU interrupt |
| cmd_o | output | CMD_W | Command word |

## Verification
The bench writes 0 to a set-once lock after setting it. A design that treated the lock as plain read/write would drop the bit and release `brk_en_o` early.

The bench raises erase flag 0, applies a system reset, and reads the flag back. A design that tied the flag to the combined reset would lose it. The bench also clears one erase flag and confirms the other stays set, which catches a design that mixes up the clear mask.

The bench flips the code-source bit in both directions while the hardware value and the software code differ, and it drops the oscillator enable while the cell reports ready. A design that wired the mux backwards, or passed the ready input through ungated, would show it at the ports.

Non-secure reads, non-secure writes and writes to the security control register are checked against readback from a secure access. A design that applied a guard to the wrong group, or that let a non-secure write change the security control register, would leak or corrupt state.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

    typedef enum logic [3:0] {
        RID_SEC,
        RID_CFG1,
        RID_FPU,
        RID_NSLK,
        RID_SLK,
        RID_CFG2,
        RID_ERASE,
        RID_CCTL,
        RID_CVAL,
        RID_CCODE,
        RID_CMD,
        RID_NONE
    } reg_id_e;

    // Guard bit positions inside the security control register
    localparam int SECB_SYS = 0;
    localparam int SECB_CLB = 1;
    localparam int SECB_FPU = 3;
    localparam logic [3:0] SEC_WMASK = 4'b1011;

    function automatic reg_id_e decode_word(input logic [7:0] w);
        reg_id_e r;
        case (w)
            8'd0:    r = RID_SEC;
            8'd1:    r = RID_CFG1;
            8'd2:    r = RID_FPU;
            8'd3:    r = RID_NSLK;
            8'd4:    r = RID_SLK;
            8'd5:    r = RID_CFG2;
            8'd6:    r = RID_ERASE;
            8'd7:    r = RID_CCTL;
            8'd8:    r = RID_CVAL;
            8'd9:    r = RID_CCODE;
            8'd11:   r = RID_CMD;
            default: r = RID_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
    import syscfg_pkg::*;
(
    input  reg_id_e    rid_i,
    input  logic       secure_i,
    input  logic [3:0] sec_cfg_i,
    output logic       rd_ok_o,
    output logic       wr_ok_o
);
    logic guarded;

    always_comb begin
        unique case (rid_i)
            RID_ERASE, RID_CCTL, RID_CVAL, RID_CCODE: guarded = sec_cfg_i[SECB_SYS];
            RID_CFG2:                                 guarded = sec_cfg_i[SECB_CLB];
            RID_FPU:                                  guarded = sec_cfg_i[SECB_FPU];
            default:                                  guarded = 1'b0;
        endcase
    end

    assign rd_ok_o = secure_i | ~guarded;
    assign wr_ok_o = rd_ok_o & ((rid_i != RID_SEC) | secure_i);
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic         set_en_i,
    input  logic [W-1:0] set_bits_i,
    output logic [W-1:0] lock_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i)
                bit_q <= 1'b0;
            else if (set_en_i && set_bits_i[g])
                bit_q <= 1'b1;
        end
        assign lock_o[g] = bit_q;
    end
endmodule

// File: rtl/cfg_erase_flags.sv
module cfg_erase_flags (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       rst_n_i,
    input  logic       all_done_i,
    input  logic       cache_done_i,
    input  logic       clr_en_i,
    input  logic [1:0] clr_bits_i,
    output logic [1:0] flags_o
);
    logic all_q, cache_q;

    // Flag 0 is tied to power-on reset only
    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i)
            all_q <= 1'b0;
        else if (all_done_i)
            all_q <= 1'b1;
        else if (clr_en_i && clr_bits_i[0])
            all_q <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i)
            cache_q <= 1'b0;
        else if (cache_done_i)
            cache_q <= 1'b1;
        else if (clr_en_i && clr_bits_i[1])
            cache_q <= 1'b0;
    end

    assign flags_o = {cache_q, all_q};
endmodule

// File: rtl/cfg_comp_mux.sv
module cfg_comp_mux #(
    parameter int CODE_HALF = 4
) (
    input  logic                   sel_sw_i,
    input  logic [2*CODE_HALF-1:0] sw_code_i,
    input  logic [2*CODE_HALF-1:0] hw_val_i,
    output logic [2*CODE_HALF-1:0] code_o
);
    assign code_o = sel_sw_i ? sw_code_i : hw_val_i;
endmodule

// File: rtl/syscfg_bank.sv
module syscfg_bank
    import syscfg_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int CODE_HALF = 4,
    parameter int CMD_W     = 16,
    parameter int FPU_N     = 6,
    parameter int NSLK_N    = 2,
    parameter int SLK_N     = 3,
    parameter int BRK_N     = 4,
    parameter int FMP_N     = 4
) (
    input  logic                   clk_i,
    input  logic                   por_n_i,
    input  logic                   sys_n_i,
    input  logic                   bus_sel_i,
    input  logic                   bus_wr_i,
    input  logic                   bus_secure_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [31:0]            bus_wdata_i,
    output logic [31:0]            bus_rdata_o,
    input  logic                   erase_all_done_i,
    input  logic                   erase_cache_done_i,
    input  logic                   cell_rdy_i,
    input  logic                   osc_en_i,
    input  logic [2*CODE_HALF-1:0] cell_val_i,
    input  logic [FPU_N-1:0]       fpu_exc_i,
    output logic [BRK_N-1:0]       brk_en_o,
    output logic [NSLK_N-1:0]      ns_lock_o,
    output logic [SLK_N-1:0]       s_lock_o,
    output logic [FMP_N-1:0]       fmp_en_o,
    output logic                   sw_boost_o,
    output logic                   sw_vsel_o,
    output logic                   comp_en_o,
    output logic [2*CODE_HALF-1:0] comp_code_o,
    output logic                   fpu_irq_o,
    output logic [CMD_W-1:0]       cmd_o
);
    localparam int CODE_W    = 2 * CODE_HALF;
    localparam int FMP_LSB   = 16;
    localparam int BOOST_BIT = 8;
    localparam int VSEL_BIT  = 9;
    localparam int RDY_BIT   = 8;
    localparam int CACHE_BIT = 16;

    logic              rst_all_n;
    reg_id_e           rid;
    logic              rd_ok, wr_ok, wr_fire;
    logic [3:0]        sec_q;
    logic              boost_q, vsel_q;
    logic [FMP_N-1:0]  fmp_q;
    logic [FPU_N-1:0]  fpu_mask_q;
    logic              comp_en_q, comp_sel_q;
    logic [CODE_W-1:0] ccode_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [1:0]        erase_flags;

    assign rst_all_n = por_n_i & sys_n_i;
    assign rid       = decode_word(8'(bus_addr_i[ADDR_W-1:2]));
    assign wr_fire   = bus_sel_i & bus_wr_i & wr_ok;

    cfg_access_gate u_gate (
        .rid_i     (rid),
        .secure_i  (bus_secure_i),
        .sec_cfg_i (sec_q),
        .rd_ok_o   (rd_ok),
        .wr_ok_o   (wr_ok)
    );

    cfg_lock_bank #(.W(BRK_N)) u_brk (
        .clk_i      (clk_i),
        .rst_n_i    (rst_all_n),
        .set_en_i   (wr_fire && rid == RID_CFG2),
        .set_bits_i (bus_wdata_i[BRK_N-1:0]),
        .lock_o     (brk_en_o)
    );

    cfg_lock_bank #(.W(NSLK_N)) u_nslk (
        .clk_i      (clk_i),
        .rst_n_i    (rst_all_n),
        .set_en_i   (wr_fire && rid == RID_NSLK),
        .set_bits_i (bus_wdata_i[NSLK_N-1:0]),
        .lock_o     (ns_lock_o)
    );

    cfg_lock_bank #(.W(SLK_N)) u_slk (
        .clk_i      (clk_i),
        .rst_n_i    (rst_all_n),
        .set_en_i   (wr_fire && rid == RID_SLK),
        .set_bits_i (bus_wdata_i[SLK_N-1:0]),
        .lock_o     (s_lock_o)
    );

    cfg_erase_flags u_erase (
        .clk_i        (clk_i),
        .por_n_i      (por_n_i),
        .rst_n_i      (rst_all_n),
        .all_done_i   (erase_all_done_i),
        .cache_done_i (erase_cache_done_i),
        .clr_en_i     (wr_fire && rid == RID_ERASE),
        .clr_bits_i   ({bus_wdata_i[CACHE_BIT], bus_wdata_i[0]}),
        .flags_o      (erase_flags)
    );

    cfg_comp_mux #(.CODE_HALF(CODE_HALF)) u_cmux (
        .sel_sw_i  (comp_sel_q),
        .sw_code_i (ccode_q),
        .hw_val_i  (cell_val_i),
        .code_o    (comp_code_o)
    );

    // Plain read/write registers
    always_ff @(posedge clk_i or negedge rst_all_n) begin
        if (!rst_all_n) begin
            sec_q      <= '0;
            boost_q    <= 1'b0;
            vsel_q     <= 1'b0;
            fmp_q      <= '0;
            fpu_mask_q <= '0;
            comp_en_q  <= 1'b0;
            comp_sel_q <= 1'b0;
            ccode_q    <= '0;
            cmd_q      <= '0;
        end else if (wr_fire) begin
            unique case (rid)
                RID_SEC:   sec_q <= bus_wdata_i[3:0] & SEC_WMASK;
                RID_CFG1: begin
                    boost_q <= bus_wdata_i[BOOST_BIT];
                    vsel_q  <= bus_wdata_i[VSEL_BIT];
                    fmp_q   <= bus_wdata_i[FMP_LSB +: FMP_N];
                end
                RID_FPU:   fpu_mask_q <= bus_wdata_i[FPU_N-1:0];
                RID_CCTL: begin
                    comp_en_q  <= bus_wdata_i[0];
                    comp_sel_q <= bus_wdata_i[1];
                end
                RID_CCODE: ccode_q <= bus_wdata_i[CODE_W-1:0];
                RID_CMD:   cmd_q   <= bus_wdata_i[CMD_W-1:0];
                default:   ;
            endcase
        end
    end

    // Read path
    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && rd_ok) begin
            unique case (rid)
                RID_SEC:   bus_rdata_o[3:0] = sec_q;
                RID_CFG1: begin
                    bus_rdata_o[BOOST_BIT]          = boost_q;
                    bus_rdata_o[VSEL_BIT]           = vsel_q;
                    bus_rdata_o[FMP_LSB +: FMP_N]   = fmp_q;
                end
                RID_FPU:   bus_rdata_o[FPU_N-1:0]  = fpu_mask_q;
                RID_NSLK:  bus_rdata_o[NSLK_N-1:0] = ns_lock_o;
                RID_SLK:   bus_rdata_o[SLK_N-1:0]  = s_lock_o;
                RID_CFG2:  bus_rdata_o[BRK_N-1:0]  = brk_en_o;
                RID_ERASE: begin
                    bus_rdata_o[0]         = erase_flags[0];
                    bus_rdata_o[CACHE_BIT] = erase_flags[1];
                end
                RID_CCTL: begin
                    bus_rdata_o[0]       = comp_en_q;
                    bus_rdata_o[1]       = comp_sel_q;
                    bus_rdata_o[RDY_BIT] = cell_rdy_i & osc_en_i;
                end
                RID_CVAL:  bus_rdata_o[CODE_W-1:0] = cell_val_i;
                RID_CCODE: bus_rdata_o[CODE_W-1:0] = ccode_q;
                RID_CMD:   bus_rdata_o[CMD_W-1:0]  = cmd_q;
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    assign fmp_en_o   = fmp_q;
    assign sw_boost_o = boost_q;
    assign sw_vsel_o  = vsel_q;
    assign comp_en_o  = comp_en_q;
    assign fpu_irq_o  = |(fpu_exc_i & fpu_mask_q);
    assign cmd_o      = cmd_q;
endmodule

// File: rtl/syscfg_bank_chk.sv
module syscfg_bank_chk #(
    parameter int ADDR_W    = 6,
    parameter int CODE_HALF = 4,
    parameter int FPU_N     = 6,
    parameter int NSLK_N    = 2,
    parameter int SLK_N     = 3,
    parameter int BRK_N     = 4
) (
    input logic                   clk_i,
    input logic                   rst_all_n,
    input logic                   bus_sel_i,
    input logic                   bus_wr_i,
    input logic                   bus_secure_i,
    input logic [ADDR_W-1:0]      bus_addr_i,
    input logic [31:0]            bus_rdata_o,
    input logic                   osc_en_i,
    input logic [2*CODE_HALF-1:0] cell_val_i,
    input logic [FPU_N-1:0]       fpu_exc_i,
    input logic [BRK_N-1:0]       brk_en_o,
    input logic [NSLK_N-1:0]      ns_lock_o,
    input logic [SLK_N-1:0]       s_lock_o,
    input logic [2*CODE_HALF-1:0] comp_code_o,
    input logic                   fpu_irq_o,
    input logic                   erase_cache_done_i,
    input logic [1:0]             erase_flags,
    input logic                   comp_sel_q,
    input logic [3:0]             sec_q
);
    logic [7:0] word;
    assign word = 8'(bus_addr_i[ADDR_W-1:2]);

    AST_BRK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (($past(brk_en_o) & ~brk_en_o) == '0)); // R2
    AST_NSLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (($past(ns_lock_o) & ~ns_lock_o) == '0)); // R3
    AST_SLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (($past(s_lock_o) & ~s_lock_o) == '0)); // R3
    AST_CACHE_SET: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        erase_cache_done_i |=> erase_flags[1]); // R5
    AST_HW_CODE: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        !comp_sel_q |-> (comp_code_o == cell_val_i)); // R6
    AST_RDY_OSC: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (bus_sel_i && word == 8'd7 && !osc_en_i) |-> !bus_rdata_o[8]); // R7
    AST_FPU_QUIET: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (fpu_exc_i == '0) |-> !fpu_irq_o); // R8
    AST_NS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (bus_sel_i && !bus_secure_i && sec_q[3] && word == 8'd2) |-> (bus_rdata_o == '0)); // R9
    AST_SEC_GUARD: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (bus_sel_i && bus_wr_i && !bus_secure_i && word == 8'd0) |=> $stable(sec_q)); // R10
    AST_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_all_n)
        (bus_sel_i && word == 8'd10) |-> (bus_rdata_o == '0)); // R11
endmodule

bind syscfg_bank syscfg_bank_chk #(
    .ADDR_W(ADDR_W), .CODE_HALF(CODE_HALF), .FPU_N(FPU_N),
    .NSLK_N(NSLK_N), .SLK_N(SLK_N), .BRK_N(BRK_N)
) u_chk (.*);

// File: tb/sim_syscfg_bank.sv
module sim_syscfg_bank;
    logic        clk_i = 1'b0;
    logic        por_n_i = 1'b0, sys_n_i = 1'b0;
    logic        bus_sel_i = 1'b0, bus_wr_i = 1'b0, bus_secure_i = 1'b1;
    logic [5:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        erase_all_done_i = 1'b0, erase_cache_done_i = 1'b0;
    logic        cell_rdy_i = 1'b0, osc_en_i = 1'b0;
    logic [7:0]  cell_val_i = '0;
    logic [5:0]  fpu_exc_i = '0;
    logic [3:0]  brk_en_o;
    logic [1:0]  ns_lock_o;
    logic [2:0]  s_lock_o;
    logic [3:0]  fmp_en_o;
    logic        sw_boost_o, sw_vsel_o, comp_en_o, fpu_irq_o;
    logic [7:0]  comp_code_o;
    logic [15:0] cmd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk_i = ~clk_i;  // 125 MHz

    syscfg_bank u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk_i);
        bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d; bus_secure_i = sec;
        @(negedge clk_i);
        bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = '0; bus_secure_i = 1;
    endtask

    task automatic rd(input logic [5:0] a, input logic sec, output logic [31:0] d);
        @(negedge clk_i);
        bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a; bus_secure_i = sec;
        #1 d = bus_rdata_o;
        bus_sel_i = 0; bus_secure_i = 1;
    endtask

    task automatic sys_reset();
        @(negedge clk_i); sys_n_i = 0;
        @(negedge clk_i); sys_n_i = 1;
    endtask

    task automatic por_reset();
        @(negedge clk_i); por_n_i = 0;
        @(negedge clk_i); por_n_i = 1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        for (int w = 0; w < 12; w++) begin
            rd(6'(w * 4), 1'b1, d);
            check($sformatf("R1 reset word %0d", w), d, 32'h0);
        end
        check("R1 reset outputs", {brk_en_o, ns_lock_o, s_lock_o, comp_code_o, cmd_o},
              32'h0);
    endtask

    task automatic t_cfg1_cmd();
        logic [31:0] d;
        wr(6'h04, 32'hFFFF_FFFF, 1);
        rd(6'h04, 1, d);
        check("R12 cfg1 readback", d, 32'h000F_0300);
        check("R12 cfg1 outputs", {26'h0, fmp_en_o, sw_vsel_o, sw_boost_o}, 32'h3F);
        wr(6'h2C, 32'h1234_5678, 1);
        rd(6'h2C, 1, d);
        check("R12 cmd readback", d, 32'h0000_5678);
        check("R12 cmd output", {16'h0, cmd_o}, 32'h5678);
        sys_reset();
        rd(6'h2C, 1, d);
        check("R1 cmd cleared by system reset", d, 32'h0);
    endtask

    task automatic t_locks();
        logic [31:0] d;
        wr(6'h14, 32'h5, 1);
        check("R2 brk set", {28'h0, brk_en_o}, 32'h5);
        wr(6'h14, 32'h0, 1);
        rd(6'h14, 1, d);
        check("R2 zero write ignored", d, 32'h5);
        wr(6'h14, 32'hA, 1);
        check("R2 brk accumulate", {28'h0, brk_en_o}, 32'hF);
        wr(6'h0C, 32'h3, 1);
        wr(6'h10, 32'h7, 1);
        wr(6'h0C, 32'h0, 1);
        check("R3 lock outputs", {27'h0, ns_lock_o, s_lock_o}, 32'h1F);
        sys_reset();
        check("R3 locks cleared by reset", {23'h0, brk_en_o, ns_lock_o, s_lock_o}, 32'h0);
    endtask

    task automatic t_erase();
        logic [31:0] d;
        @(negedge clk_i); erase_all_done_i = 1;
        @(negedge clk_i); erase_all_done_i = 0; erase_cache_done_i = 1;
        @(negedge clk_i); erase_cache_done_i = 0;
        rd(6'h18, 1, d);
        check("R4 R5 both flags set", d, 32'h0001_0001);
        wr(6'h18, 32'h0001_0000, 1);
        rd(6'h18, 1, d);
        check("R5 clear bit16 keeps bit0", d, 32'h0000_0001);
        sys_reset();
        rd(6'h18, 1, d);
        check("R4 bit0 survives system reset", d, 32'h0000_0001);
        // set and clear in same cycle: set wins
        @(negedge clk_i);
        bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 6'h18; bus_wdata_i = 32'h1; erase_all_done_i = 1;
        @(negedge clk_i);
        bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = '0; erase_all_done_i = 0;
        rd(6'h18, 1, d);
        check("R4 set beats clear", d, 32'h1);
        wr(6'h18, 32'h1, 1);
        rd(6'h18, 1, d);
        check("R4 write-1 clears bit0", d, 32'h0);
        @(negedge clk_i); erase_all_done_i = 1;
        @(negedge clk_i); erase_all_done_i = 0;
        por_reset();
        rd(6'h18, 1, d);
        check("R1 power-on reset clears bit0", d, 32'h0);
    endtask

    task automatic t_comp();
        logic [31:0] d;
        cell_val_i = 8'hA5;
        wr(6'h24, 32'h3C, 1);
        wr(6'h1C, 32'h1, 1);
        check("R6 hw value selected", {24'h0, comp_code_o}, 32'hA5);
        check("R6 enable out", {31'h0, comp_en_o}, 32'h1);
        wr(6'h1C, 32'h3, 1);
        check("R6 sw code selected", {24'h0, comp_code_o}, 32'h3C);
        wr(6'h1C, 32'h1, 1);
        check("R6 back to hw value", {24'h0, comp_code_o}, 32'hA5);
        wr(6'h20, 32'hFF, 1);
        rd(6'h20, 1, d);
        check("R11 value reg read-only", d, 32'hA5);
        cell_rdy_i = 1; osc_en_i = 0;
        rd(6'h1C, 1, d);
        check("R7 ready masked by oscillator", d, 32'h1);
        osc_en_i = 1;
        rd(6'h1C, 1, d);
        check("R7 ready visible", d, 32'h101);
    endtask

    task automatic t_fpu();
        wr(6'h08, 32'h06, 1);
        fpu_exc_i = 6'h01; #1;
        check("R8 masked invalid", {31'h0, fpu_irq_o}, 32'h0);
        fpu_exc_i = 6'h04; #1;
        check("R8 underflow enabled", {31'h0, fpu_irq_o}, 32'h1);
        fpu_exc_i = 6'h20; #1;
        check("R8 inexact masked", {31'h0, fpu_irq_o}, 32'h0);
        fpu_exc_i = 6'h00;
    endtask

    task automatic t_secure();
        logic [31:0] d;
        wr(6'h08, 32'h15, 1);
        wr(6'h00, 32'hF, 1);
        rd(6'h00, 0, d);
        check("R10 sec reg readback", d, 32'hB);
        rd(6'h08, 0, d);
        check("R9 ns read of fpu masked", d, 32'h0);
        wr(6'h08, 32'h3F, 0);
        rd(6'h08, 1, d);
        check("R9 ns write of fpu ignored", d, 32'h15);
        rd(6'h24, 0, d);
        check("R9 ns read of code masked", d, 32'h0);
        wr(6'h00, 32'h0, 0);
        rd(6'h00, 1, d);
        check("R10 ns write of sec ignored", d, 32'hB);
        wr(6'h00, 32'h0, 1);
        rd(6'h08, 0, d);
        check("R9 ns read after unguard", d, 32'h15);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(6'h28, 32'hFFFF_FFFF, 1);
        rd(6'h28, 1, d);
        check("R11 unmapped read 0x28", d, 32'h0);
        rd(6'h3C, 1, d);
        check("R11 unmapped read 0x3C", d, 32'h0);
        rd(6'h2C, 1, d);
        check("R11 unmapped write touched nothing", d, 32'h0);
    endtask

    initial begin
        #20;
        por_n_i = 1; sys_n_i = 1;
        t_reset_state();
        t_cfg1_cmd();
        t_locks();
        t_erase();
        t_comp();
        t_fpu();
        t_secure();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule